// File: doc/BRIEF.md
# Packed Half-word Bidirectional Shifter

This execution unit accepts one 32-bit instruction word at a time and recognises two encodings of a packed half-word shift. The 32-bit source operand holds two independent 16-bit lanes. One signed 5-bit count, in the range -16 to +15, shifts both lanes at once. A count of zero or more shifts each lane left. A negative count shifts each lane right, logically, by the count's magnitude. Zeros fill vacated positions, and bits that leave a lane are dropped. The register-count encoding takes the count from the low five bits of a second source register. The immediate encoding takes it from the low five bits of a 9-bit immediate. The unit produces a destination index, the packed result and a write enable.

The unit reads its operands through a register-file read port. It drives two read indices straight from the instruction word, and the register file returns the data in the same cycle. The result is held in a single output register. Instructions enter on a valid/ready pair, and results leave on a second valid/ready pair. An instruction is taken on a clock edge when `in_valid` and `in_ready` are both high. The unit raises `in_ready` whenever its output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds steady and no new instruction is taken. Each accepted word produces exactly one output beat. The beat is either a write (`wr_en`) or a rejection (`not_mine`).

Top module: `hw_pair_shifter`

## Requirements
- R1: A word with bits [7:0] = 0x0F and bits [27:20] = 0x40 is the register-count form. Its read index A is bits [11:8], read index B is bits [15:12], and the destination is bits [31:28]. The count is bits [4:0] of the B read data.
- R2: A word with bits [7:0] = 0x8F and bits [27:21] = 0x40 is the immediate form. Its read index A is bits [11:8], the 9-bit immediate is bits [20:12], the count is immediate bits [4:0], and the destination is bits [31:28].
- R3: The count is the two's-complement value of its 5-bit field. For a count c from 0 to 15, each 16-bit lane of operand A is shifted left by c, and the low positions fill with zeros.
- R4: For a count c from -15 to -1, each lane is shifted right logically by -c, and the high positions fill with zeros, whatever the lane's top bit.
- R5: Lanes are independent. Bits leaving lane 0 never appear in lane 1, and bits leaving lane 1 never appear in lane 0.
- R6: A count of -16 (field value 0x10) gives an all-zero result.
- R7: Register B bits [31:5] and immediate bits [8:5] have no effect on the result.
- R8: A word that matches neither form produces a beat with `wr_en` low and `not_mine` high. In that beat, `wr_idx` and `wr_data` keep their previous values.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `wr_en`, `not_mine`, `wr_idx` and `wr_data` stay constant.
- R10: After reset, `out_valid`, `wr_en` and `not_mine` are low, and `wr_idx` and `wr_data` are zero.
- R11: An instruction accepted on one clock edge is visible as `out_valid` after that edge, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| rf_rd_a_idx | output | 4 | Read index for the shifted operand |
| rf_rd_a_data | input | 32 | Operand data for index A |
| rf_rd_b_idx | output | 4 | Read index for the count register |
| rf_rd_b_data | input | 32 | Count register data for index B |
| out_valid | output | 1 | A result beat is present |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| wr_en | output | 1 | Beat is a register write |
| not_mine | output | 1 | Beat rejects an unrecognised word |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Packed shift result |

## Verification
A decode fault shows up on the beat that follows the accepting edge. If the fault is in a fixed opcode comparison, `not_mine` rises where `wr_en` should rise, or the other way round. If the fault is in the count path, the wrong value appears in one or both lanes of `wr_data` within that same cycle. Two kinds of fault appear only under particular data. A lane boundary that leaks or a right shift that is arithmetic shows only when set bits sit at the lane edges or in the lane sign bits. For that reason every count from -16 to +15 is swept against patterns that hold ones at positions 0, 15, 16 and 31. A held-output fault appears during the first stalled cycle as a change in the data or flags while `out_ready` is low.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int INSTR_W   = 32;
  localparam int IDX_W     = 4;
  localparam logic [7:0] OPC_REG = 8'h0F;
  localparam logic [7:0] OPC_IMM = 8'h8F;
  localparam logic [7:0] SUB_REG = 8'h40;
  localparam logic [6:0] SUB_IMM = 7'h40;

  typedef struct packed {
    logic             hit;
    logic             use_imm;
    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic [IDX_W-1:0] idx_c;
    logic [8:0]       imm9;
  } dec_t;
endpackage

// File: rtl/hps_decode.sv
module hps_decode
  import hps_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic is_reg, is_imm;

  always_comb begin
    is_reg = (instr_i[7:0] == OPC_REG) && (instr_i[27:20] == SUB_REG);
    is_imm = (instr_i[7:0] == OPC_IMM) && (instr_i[27:21] == SUB_IMM);
    dec_o.hit     = is_reg || is_imm;
    dec_o.use_imm = is_imm;
    dec_o.idx_a   = instr_i[11:8];
    dec_o.idx_b   = instr_i[15:12];
    dec_o.idx_c   = instr_i[31:28];
    dec_o.imm9    = instr_i[20:12];
  end
endmodule

// File: rtl/hps_lane.sv
module hps_lane #(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [LANE_W-1:0] din_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [LANE_W-1:0] dout_o
);
  logic [CNT_W:0] mag;

  always_comb begin
    mag = '0;
    if (!cnt_i[CNT_W-1]) begin
      dout_o = din_i << cnt_i;
    end else begin
      mag    = {(CNT_W+1){1'b0}} - {1'b1, cnt_i};
      dout_o = din_i >> mag;
    end
  end
endmodule

// File: rtl/hw_pair_shifter.sv
module hw_pair_shifter
  import hps_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [31:0]             in_instr,
  output logic [3:0]              rf_rd_a_idx,
  input  logic [LANE_W*LANES-1:0] rf_rd_a_data,
  output logic [3:0]              rf_rd_b_idx,
  input  logic [LANE_W*LANES-1:0] rf_rd_b_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    wr_en,
  output logic                    not_mine,
  output logic [3:0]              wr_idx,
  output logic [LANE_W*LANES-1:0] wr_data
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int CNT_W  = $clog2(LANE_W) + 1;

  dec_t              dec;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shifted;
  logic              take;
  logic              hit_q;

  hps_decode u_dec (
    .instr_i (in_instr),
    .dec_o   (dec)
  );

  assign rf_rd_a_idx = dec.idx_a;
  assign rf_rd_b_idx = dec.idx_b;
  assign cnt = dec.use_imm ? dec.imm9[CNT_W-1:0] : rf_rd_b_data[CNT_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hps_lane #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_lane (
      .din_i  (rf_rd_a_data[g*LANE_W +: LANE_W]),
      .cnt_i  (cnt),
      .dout_o (shifted[g*LANE_W +: LANE_W])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hit_q     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        hit_q     <= dec.hit;
        if (dec.hit) begin
          wr_idx  <= dec.idx_c;
          wr_data <= shifted;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign wr_en    = out_valid && hit_q;
  assign not_mine = out_valid && !hit_q;
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              wr_en,
  input logic              not_mine,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(wr_data) && $stable(wr_idx) && $stable(wr_en)); // R9
  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    not_mine |-> $stable(wr_data) && $stable(wr_idx)); // R8
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({wr_en, not_mine}) == 1); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wr_en && !not_mine); // R10
  AST_NEXT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R11
endmodule

bind hw_pair_shifter hps_checker #(.DATA_W(LANE_W*LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .wr_en     (wr_en),
  .not_mine  (not_mine),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data)
);

// File: tb/hw_pair_shifter_tb.sv
module hw_pair_shifter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [3:0]  rf_rd_a_idx, rf_rd_b_idx;
  logic [31:0] rf_rd_a_data, rf_rd_b_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        wr_en, not_mine;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [31:0] rf [16];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rd_a_data = rf[rf_rd_a_idx];
  assign rf_rd_b_data = rf[rf_rd_b_idx];

  hw_pair_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .rf_rd_a_idx(rf_rd_a_idx), .rf_rd_a_data(rf_rd_a_data),
    .rf_rd_b_idx(rf_rd_b_idx), .rf_rd_b_data(rf_rd_b_data), .out_valid(out_valid),
    .out_ready(out_ready), .wr_en(wr_en), .not_mine(not_mine), .wr_idx(wr_idx),
    .wr_data(wr_data)
  );

  function automatic logic [31:0] ref_shift(logic [31:0] v, logic [4:0] f);
    int s;
    int r0, r1;
    s = f[4] ? int'(f) - 32 : int'(f);
    if (s >= 0) begin
      r0 = (int'(v[15:0]) << s) & 32'hFFFF;
      r1 = (int'(v[31:16]) << s) & 32'hFFFF;
    end else begin
      r0 = int'(v[15:0]) >> (-s);
      r1 = int'(v[31:16]) >> (-s);
    end
    return {r1[15:0], r0[15:0]};
  endfunction

  function automatic logic [31:0] enc_reg(logic [3:0] c, logic [3:0] a, logic [3:0] b);
    return {c, 8'h40, 4'h0, b, a, 8'h0F};
  endfunction

  function automatic logic [31:0] enc_imm(logic [3:0] c, logic [3:0] a, logic [8:0] imm);
    return {c, 7'h40, imm, a, 8'h8F};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w);
    @(negedge clk);
    in_instr = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  logic [31:0] pats [5] = '{32'h8001_8001, 32'hFFFF_0000, 32'h0000_FFFF,
                            32'hA5C3_3C5A, 32'h7FFE_8001};

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {31'h0, out_valid}, 32'h0);
    check("R10 flags", {30'h0, wr_en, not_mine}, 32'h0);
    check("R10 wr_data", wr_data, 32'h0);
    check("R10 wr_idx", {28'h0, wr_idx}, 32'h0);
    rst_n = 1'b1;

    // R1 R3 R4 R5 R6 R7 R11: sweep every count, register-count form
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 32; k++) begin
        logic [3:0] a, b, c;
        a = 4'(k % 7 + 1);
        b = a + 4'd8;
        c = 4'(k);
        rf[a] = pats[p];
        rf[b] = {27'h5A5_5A5A ^ 27'(k * 977), 5'(k)};
        issue(enc_reg(c, a, b));
        check("R11 out_valid", {31'h0, out_valid}, 32'h1);
        check("R1 wr_en/idx", {27'h0, wr_en, wr_idx}, {27'h0, 1'b1, c});
        check(k == 16 ? "R6 reg form" : (k < 16 ? "R3 R5 R7 reg left" : "R4 R5 R7 reg right"),
              wr_data, ref_shift(pats[p], 5'(k)));
      end
    end

    // R2 R3 R4 R5 R6 R7: sweep every count, immediate form
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 32; k++) begin
        logic [3:0] a, c;
        a = 4'(15 - (k % 5));
        c = 4'(31 - k);
        rf[a] = pats[p];
        issue(enc_imm(c, a, {4'(k * 3 + p), 5'(k)}));
        check("R2 wr_en/idx", {27'h0, wr_en, wr_idx}, {27'h0, 1'b1, c});
        check(k == 16 ? "R6 imm form" : (k < 16 ? "R3 R5 R7 imm left" : "R4 R5 R7 imm right"),
              wr_data, ref_shift(pats[p], 5'(k)));
      end
    end

    // R8: unrecognised words keep previous index and data
    rf[3] = 32'h1234_8765;
    issue(enc_imm(4'd9, 4'd3, 9'h002));
    check("R8 setup", wr_data, 32'h48D0_1D94);
    issue({4'd5, 8'h40, 4'h0, 4'd1, 4'd3, 8'h8F});
    check("R8 flags", {30'h0, wr_en, not_mine}, 32'h1);
    check("R8 data held", wr_data, 32'h48D0_1D94);
    check("R8 idx held", {28'h0, wr_idx}, 32'h9);
    issue({4'd6, 8'h41, 4'h0, 4'd1, 4'd3, 8'h0F});
    check("R8 flags sub", {30'h0, wr_en, not_mine}, 32'h1);
    check("R8 data held sub", wr_data, 32'h48D0_1D94);

    // R9: stalled output holds; next word waits
    @(negedge clk);
    out_ready = 1'b0;
    in_instr = enc_imm(4'd2, 4'd3, 9'h1F);
    in_valid = 1'b1;
    @(negedge clk);
    in_instr = enc_imm(4'd4, 4'd3, 9'h01);
    for (int i = 0; i < 3; i++) begin
      check("R9 in_ready low", {31'h0, in_ready}, 32'h0);
      check("R9 held data", wr_data, ref_shift(32'h1234_8765, 5'h1F));
      check("R9 held idx", {27'h0, wr_en, wr_idx}, {27'h0, 1'b1, 4'd2});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 after release", wr_data, ref_shift(32'h1234_8765, 5'h01));
    check("R9 idx after release", {28'h0, wr_idx}, 32'h4);
    @(negedge clk);
    check("R9 drained", {31'h0, out_valid}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule